// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block sits between a requester and a bit-level two-wire bus engine. It runs one complete SMBus or I2C host transaction per request. A request carries a transaction type, a 7-bit target address, a command byte and a length. The sequencer breaks the transaction into engine primitives: START, repeated START, STOP, byte write and byte read.

The engine handles SCL/SDA timing, clock stretching and arbitration. For every write primitive the engine reports whether the target acknowledged. Write payload bytes are not stored inside the block. The sequencer publishes a byte index, and the requester answers in the same cycle with the byte from its own buffer. Each received data byte is delivered on a one-cycle strobe together with its index. At the end of the transaction a done pulse presents a status code and the number of data bytes received.

Top module: `smbus_txn_seq`

## Requirements
- R1: Type codes are 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read, 10 block process call, 11 I2C block write, 12 I2C block read; codes 13 to 15 behave as quick. `busy` rises the cycle after `reqValid` is seen while idle. A request presented while busy is ignored and produces no primitive. `done` is a one-cycle pulse while `busy` is high, and `busy` is low in the following cycle. At most one primitive is outstanding at a time.
- R2: Every address byte is the 7-bit address in bits 7:1 with the direction in bit 0 (1 = read, 0 = write). A quick transaction issues START, the address byte with `reqCmd[0]` as its direction bit, then STOP.
- R3: Send byte issues START, address-write, write byte index 0, STOP. Write byte and write word insert the command byte after the address. Write word sends index 0 (low byte) and then index 1 (high byte).
- R4: Receive byte issues START, address-read, one read answered with NACK, then STOP.
- R5: Read byte and read word issue START, address-write and the command byte, then a repeated START and address-read. They then perform 1 or 2 reads, low byte first. Every read except the last is answered with ACK and the last with NACK.
- R6: Process call writes the command byte and data indexes 0 and 1, then issues a repeated START and address-read and reads two bytes.
- R7: Block write sends the command byte, then a count byte equal to `reqLen`, then `reqLen` data bytes from indexes 0 upward.
- R8: Block read, after the address-read, first reads a count byte, answered with ACK and not reported as data. It then reads exactly that many data bytes, and the final status reports that count.
- R9: A received count of 0, or above `MAX_BLOCK` (above `MAX_BLOCK`-1 for block process call), ends the transaction with STOP directly after the count byte. The status is then 2 and the received count 0.
- R10: Block process call writes the command byte, a count byte of `reqLen` and `reqLen` data bytes. It then issues a repeated START and address-read, reads a device count and then reads that many bytes.
- R11: I2C block write sends the command byte and `reqLen` data bytes with no count byte. I2C block read writes the command byte, then issues a repeated START and address-read and reads `reqLen` bytes with no count byte.
- R12: A NACK reported on any byte the host writes (address, command, count or data) is followed immediately by STOP and nothing else. The status is then 1. Status 0 means success.
- R13: Each received data byte appears on `rdData` with `rdIdx` (0-based) during a one-cycle `rdValid` pulse, one cycle after the engine completes that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqType | input | 4 | Transaction type code |
| reqAddr | input | 7 | Target address |
| reqCmd | input | 8 | Command byte; bit 0 is the direction for quick |
| reqLen | input | IDX_W (6) | Write length for block/I2C writes, read length for I2C block read |
| busy | output | 1 | Transaction in progress |
| wrIdx | output | IDX_W (6) | Index of the write payload byte requested |
| wrByte | input | 8 | Payload byte at `wrIdx`, supplied in the same cycle |
| rdValid | output | 1 | Received data byte strobe |
| rdIdx | output | IDX_W (6) | Index of the received byte |
| rdData | output | 8 | Received byte |
| done | output | 1 | End-of-transaction pulse |
| status | output | 2 | 0 ok, 1 target NACK, 2 bad count |
| rxCount | output | IDX_W (6) | Data bytes received, valid at `done` |
| priGo | output | 1 | Issue primitive (one-cycle pulse) |
| priCmd | output | 3 | 1 START, 2 repeated START, 3 STOP, 4 write, 5 read |
| priData | output | 8 | Byte for a write primitive |
| priNackOut | output | 1 | For a read primitive: answer with NACK |
| engDone | input | 1 | Engine finished the outstanding primitive |
| engNack | input | 1 | With `engDone` after a write: target did not acknowledge |
| engRdData | input | 8 | With `engDone` after a read: byte received |

## Verification
The embedded properties take it as given that the engine raises `engDone` only while a primitive is outstanding, and never in the same cycle as the `priGo` that started it. They also assume `engNack` is meaningful only alongside `engDone`, and that `reqLen` lies in 1 to `MAX_BLOCK` for the types that use it. The bench's engine model keeps to this. It answers each primitive after a latency of one to three cycles, raises NACK only on the write it was told to refuse, and returns device bytes from a queue prepared for the transaction. Every request uses a legal length. Counts outside the legal range are produced only by the device model, because that is the case the block must reject.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [3:0] {
    T_QUICK  = 4'd0,
    T_SEND   = 4'd1,
    T_RECV   = 4'd2,
    T_WBYTE  = 4'd3,
    T_RBYTE  = 4'd4,
    T_WWORD  = 4'd5,
    T_RWORD  = 4'd6,
    T_PCALL  = 4'd7,
    T_BWRITE = 4'd8,
    T_BREAD  = 4'd9,
    T_BPCALL = 4'd10,
    T_I2CW   = 4'd11,
    T_I2CR   = 4'd12
  } txnType_e;

  typedef enum logic [2:0] {
    PR_NONE   = 3'd0,
    PR_START  = 3'd1,
    PR_RSTART = 3'd2,
    PR_STOP   = 3'd3,
    PR_WRITE  = 3'd4,
    PR_READ   = 3'd5
  } prim_e;

  typedef enum logic [2:0] {
    SEL_ADDRW = 3'd0,
    SEL_ADDRR = 3'd1,
    SEL_ADDRQ = 3'd2,
    SEL_CMD   = 3'd3,
    SEL_CNT   = 3'd4,
    SEL_DATA  = 3'd5
  } byteSel_e;

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_NACK = 2'd1;
  localparam logic [1:0] ST_CNT  = 2'd2;

  // Shape of one transaction, derived from its type code
  typedef struct packed {
    logic       quick;      // address byte only
    logic       rdOnly;     // address goes out with read, then data
    logic       hasCmd;     // command byte follows write address
    logic       hasWCnt;    // count byte precedes write payload
    logic       wrFromLen;  // write payload length taken from request
    logic [1:0] wrFixed;    // otherwise fixed write payload length
    logic       combined;   // repeated START and read phase follow
    logic       hasRCnt;    // device sends count before read payload
    logic       rdFromLen;  // read length taken from request
    logic [1:0] rdFixed;    // otherwise fixed read length
    logic       procLimit;  // count limit is one below the maximum
  } txnFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latch;
    logic     incWr;
    logic     incRd;
    logic     loadCnt;
    logic     captRd;
    logic     setNack;
    logic     setCntErr;
    byteSel_e sel;
  } ctrlStrobe_t;

  function automatic txnFlags_t decodeType(input logic [3:0] code);
    txnFlags_t f;
    f = '0;
    case (code)
      T_SEND:   f.wrFixed = 2'd1;
      T_RECV:   begin f.rdOnly = 1'b1; f.rdFixed = 2'd1; end
      T_WBYTE:  begin f.hasCmd = 1'b1; f.wrFixed = 2'd1; end
      T_RBYTE:  begin f.hasCmd = 1'b1; f.combined = 1'b1; f.rdFixed = 2'd1; end
      T_WWORD:  begin f.hasCmd = 1'b1; f.wrFixed = 2'd2; end
      T_RWORD:  begin f.hasCmd = 1'b1; f.combined = 1'b1; f.rdFixed = 2'd2; end
      T_PCALL:  begin
                  f.hasCmd = 1'b1; f.wrFixed = 2'd2;
                  f.combined = 1'b1; f.rdFixed = 2'd2;
                end
      T_BWRITE: begin f.hasCmd = 1'b1; f.hasWCnt = 1'b1; f.wrFromLen = 1'b1; end
      T_BREAD:  begin f.hasCmd = 1'b1; f.combined = 1'b1; f.hasRCnt = 1'b1; end
      T_BPCALL: begin
                  f.hasCmd = 1'b1; f.hasWCnt = 1'b1; f.wrFromLen = 1'b1;
                  f.combined = 1'b1; f.hasRCnt = 1'b1; f.procLimit = 1'b1;
                end
      T_I2CW:   begin f.hasCmd = 1'b1; f.wrFromLen = 1'b1; end
      T_I2CR:   begin f.hasCmd = 1'b1; f.combined = 1'b1; f.rdFromLen = 1'b1; end
      default:  f.quick = 1'b1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/smbus_seq_dp.sv
module smbus_seq_dp
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [3:0]       reqType,
  input  logic [6:0]       reqAddr,
  input  logic [7:0]       reqCmd,
  input  logic [IDX_W-1:0] reqLen,
  input  logic [7:0]       wrByte,
  input  logic [7:0]       engRdData,
  output txnFlags_t        flags,
  output logic             wrLast,
  output logic             wrZero,
  output logic             rdLast,
  output logic             cntBad,
  output logic [7:0]       priData,
  output logic [IDX_W-1:0] wrIdx,
  output logic             rdValid,
  output logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic [IDX_W-1:0] rxCount,
  output logic [1:0]       status
);

  localparam logic [7:0]       LIM_FULL = 8'(MAX_BLOCK);
  localparam logic [7:0]       LIM_PROC = 8'(MAX_BLOCK - 1);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  txnFlags_t        flagsQ, reqFlags;
  logic [6:0]       addrQ;
  logic [7:0]       cmdQ;
  logic [IDX_W-1:0] lenQ, wrLen, rdLen, wrCnt, rdCnt;
  logic [1:0]       statusQ;
  logic             rdValidQ;
  logic [7:0]       rdDataQ;
  logic [IDX_W-1:0] rdIdxQ;
  logic [7:0]       cntLimit;

  assign reqFlags = decodeType(reqType);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ   <= '0;
      addrQ    <= '0;
      cmdQ     <= '0;
      lenQ     <= '0;
      wrLen    <= '0;
      rdLen    <= '0;
      wrCnt    <= '0;
      rdCnt    <= '0;
      statusQ  <= ST_OK;
      rdValidQ <= 1'b0;
      rdDataQ  <= '0;
      rdIdxQ   <= '0;
    end else begin
      rdValidQ <= stb.captRd;
      if (stb.captRd) begin
        rdDataQ <= engRdData;
        rdIdxQ  <= rdCnt;
      end
      if (stb.latch) begin
        flagsQ  <= reqFlags;
        addrQ   <= reqAddr;
        cmdQ    <= reqCmd;
        lenQ    <= reqLen;
        wrLen   <= reqFlags.wrFromLen ? reqLen : IDX_W'(reqFlags.wrFixed);
        rdLen   <= reqFlags.rdFromLen ? reqLen : IDX_W'(reqFlags.rdFixed);
        wrCnt   <= '0;
        rdCnt   <= '0;
        statusQ <= ST_OK;
      end else begin
        if (stb.incWr)     wrCnt   <= wrCnt + ONE;
        if (stb.incRd)     rdCnt   <= rdCnt + ONE;
        if (stb.loadCnt)   rdLen   <= engRdData[IDX_W-1:0];
        if (stb.setNack)   statusQ <= ST_NACK;
        if (stb.setCntErr) statusQ <= ST_CNT;
      end
    end
  end

  // Byte placed on the engine for a write primitive
  always_comb begin
    case (stb.sel)
      SEL_ADDRW: priData = {addrQ, 1'b0};
      SEL_ADDRR: priData = {addrQ, 1'b1};
      SEL_ADDRQ: priData = {addrQ, cmdQ[0]};
      SEL_CMD:   priData = cmdQ;
      SEL_CNT:   priData = 8'(lenQ);
      SEL_DATA:  priData = wrByte;
      default:   priData = 8'h00;
    endcase
  end

  assign cntLimit = flagsQ.procLimit ? LIM_PROC : LIM_FULL;
  assign cntBad   = (engRdData == 8'd0) || (engRdData > cntLimit);
  assign wrLast   = (wrCnt == wrLen - ONE);
  assign wrZero   = (wrLen == '0);
  assign rdLast   = (rdCnt == rdLen - ONE);
  assign flags    = flagsQ;
  assign wrIdx    = wrCnt;
  assign rxCount  = rdCnt;
  assign status   = statusQ;
  assign rdValid  = rdValidQ;
  assign rdIdx    = rdIdxQ;
  assign rdData   = rdDataQ;

  // R8: reported data indexes never reach the block limit
  p_rd_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdIdx < IDX_W'(MAX_BLOCK)));

  // R12: a refused write leaves the NACK code in status once the strobe lands
  p_nack_status_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setNack && !stb.latch) |=> (status == ST_NACK));

endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  txnFlags_t   flags,
  input  logic        wrLast,
  input  logic        wrZero,
  input  logic        rdLast,
  input  logic        cntBad,
  input  logic        engDone,
  input  logic        engNack,
  output ctrlStrobe_t stb,
  output logic        priGo,
  output prim_e       priCmd,
  output logic        priNackOut,
  output logic        busy,
  output logic        done
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_WCNT, S_WDAT,
    S_RSTART, S_RADDR, S_RCNT, S_RDAT, S_STOP, S_DONE
  } state_e;

  state_e state, nextState, afterWrites;
  logic   issued, fin, writeState, fault;

  assign writeState = (state == S_ADDR) || (state == S_CMD) || (state == S_WCNT) ||
                      (state == S_WDAT) || (state == S_RADDR);
  assign fin        = issued && engDone;
  assign fault      = engNack && writeState;
  assign afterWrites = flags.combined ? S_RSTART : S_STOP;

  always_comb begin
    nextState = state;
    case (state)
      S_START:  nextState = S_ADDR;
      S_ADDR: begin
        if (fault || flags.quick) nextState = S_STOP;
        else if (flags.rdOnly)    nextState = S_RDAT;
        else if (flags.hasCmd)    nextState = S_CMD;
        else                      nextState = S_WDAT;
      end
      S_CMD: begin
        if (fault)              nextState = S_STOP;
        else if (flags.hasWCnt) nextState = S_WCNT;
        else if (wrZero)        nextState = afterWrites;
        else                    nextState = S_WDAT;
      end
      S_WCNT: begin
        if (fault)       nextState = S_STOP;
        else if (wrZero) nextState = afterWrites;
        else             nextState = S_WDAT;
      end
      S_WDAT: begin
        if (fault)       nextState = S_STOP;
        else if (wrLast) nextState = afterWrites;
        else             nextState = S_WDAT;
      end
      S_RSTART: nextState = S_RADDR;
      S_RADDR: begin
        if (fault)              nextState = S_STOP;
        else if (flags.hasRCnt) nextState = S_RCNT;
        else                    nextState = S_RDAT;
      end
      S_RCNT:   nextState = cntBad ? S_STOP : S_RDAT;
      S_RDAT:   nextState = rdLast ? S_STOP : S_RDAT;
      S_STOP:   nextState = S_DONE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      issued <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) state <= S_START;
        S_DONE: state <= S_IDLE;
        default: begin
          if (!issued) begin
            issued <= 1'b1;
          end else if (engDone) begin
            issued <= 1'b0;
            state  <= nextState;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (state)
      S_START:  priCmd = PR_START;
      S_RSTART: priCmd = PR_RSTART;
      S_STOP:   priCmd = PR_STOP;
      S_RCNT,
      S_RDAT:   priCmd = PR_READ;
      S_ADDR, S_CMD, S_WCNT,
      S_WDAT, S_RADDR: priCmd = PR_WRITE;
      default:  priCmd = PR_NONE;
    endcase
  end

  assign priGo      = (state != S_IDLE) && (state != S_DONE) && !issued;
  assign priNackOut = (state == S_RDAT) && rdLast;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);

  always_comb begin
    stb           = '0;
    stb.latch     = (state == S_IDLE) && reqValid;
    stb.incWr     = fin && (state == S_WDAT) && !engNack;
    stb.incRd     = fin && (state == S_RDAT);
    stb.captRd    = fin && (state == S_RDAT);
    stb.loadCnt   = fin && (state == S_RCNT) && !cntBad;
    stb.setNack   = fin && fault;
    stb.setCntErr = fin && (state == S_RCNT) && cntBad;
    case (state)
      S_ADDR:  stb.sel = flags.quick  ? SEL_ADDRQ :
                         flags.rdOnly ? SEL_ADDRR : SEL_ADDRW;
      S_CMD:   stb.sel = SEL_CMD;
      S_WCNT:  stb.sel = SEL_CNT;
      S_WDAT:  stb.sel = SEL_DATA;
      S_RADDR: stb.sel = SEL_ADDRR;
      default: stb.sel = SEL_ADDRW;
    endcase
  end

  // R1: only one primitive in flight
  p_single_prim_r1: assert property (@(posedge clk) disable iff (!rstN)
    priGo |=> !priGo);

  // R1: an idle request is taken on the next edge
  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R12: refused write byte is followed at once by STOP
  p_nack_stop_r12: assert property (@(posedge clk) disable iff (!rstN)
    (issued && engDone && engNack && writeState) |=> (priGo && priCmd == PR_STOP));

  // R9: an illegal device count aborts with STOP
  p_count_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (issued && engDone && state == S_RCNT && cntBad) |=> (priGo && priCmd == PR_STOP));

endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int IDX_W     = $clog2(MAX_BLOCK + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [3:0]       reqType,
  input  logic [6:0]       reqAddr,
  input  logic [7:0]       reqCmd,
  input  logic [IDX_W-1:0] reqLen,
  output logic             busy,
  output logic [IDX_W-1:0] wrIdx,
  input  logic [7:0]       wrByte,
  output logic             rdValid,
  output logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic             done,
  output logic [1:0]       status,
  output logic [IDX_W-1:0] rxCount,
  output logic             priGo,
  output logic [2:0]       priCmd,
  output logic [7:0]       priData,
  output logic             priNackOut,
  input  logic             engDone,
  input  logic             engNack,
  input  logic [7:0]       engRdData
);

  ctrlStrobe_t stb;
  txnFlags_t   flags;
  prim_e       primCode;
  logic        wrLast, wrZero, rdLast, cntBad;

  smbus_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .flags      (flags),
    .wrLast     (wrLast),
    .wrZero     (wrZero),
    .rdLast     (rdLast),
    .cntBad     (cntBad),
    .engDone    (engDone),
    .engNack    (engNack),
    .stb        (stb),
    .priGo      (priGo),
    .priCmd     (primCode),
    .priNackOut (priNackOut),
    .busy       (busy),
    .done       (done)
  );

  smbus_seq_dp #(
    .MAX_BLOCK (MAX_BLOCK),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqType   (reqType),
    .reqAddr   (reqAddr),
    .reqCmd    (reqCmd),
    .reqLen    (reqLen),
    .wrByte    (wrByte),
    .engRdData (engRdData),
    .flags     (flags),
    .wrLast    (wrLast),
    .wrZero    (wrZero),
    .rdLast    (rdLast),
    .cntBad    (cntBad),
    .priData   (priData),
    .wrIdx     (wrIdx),
    .rdValid   (rdValid),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .rxCount   (rxCount),
    .status    (status)
  );

  assign priCmd = primCode;

endmodule

// File: tb/smbus_txn_seq_test.sv
`timescale 1ns/1ps
module smbus_txn_seq_test;
  import smbus_seq_pkg::*;

  localparam int MAXB = 32;
  localparam int IW   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [3:0]    reqType = '0;
  logic [6:0]    reqAddr = '0;
  logic [7:0]    reqCmd = '0;
  logic [IW-1:0] reqLen = '0;
  logic          busy, rdValid, done, priGo, priNackOut;
  logic [IW-1:0] wrIdx, rdIdx, rxCount;
  logic [7:0]    wrByte, rdData, priData;
  logic [1:0]    status;
  logic [2:0]    priCmd;
  logic          engDone = 1'b0, engNack = 1'b0;
  logic [7:0]    engRdData = '0;

  always #2 clk = ~clk;

  assign wrByte = 8'h30 + 8'(wrIdx) * 8'd3;

  smbus_txn_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqCmd(reqCmd), .reqLen(reqLen), .busy(busy),
    .wrIdx(wrIdx), .wrByte(wrByte), .rdValid(rdValid), .rdIdx(rdIdx),
    .rdData(rdData), .done(done), .status(status), .rxCount(rxCount),
    .priGo(priGo), .priCmd(priCmd), .priData(priData), .priNackOut(priNackOut),
    .engDone(engDone), .engNack(engNack), .engRdData(engRdData)
  );

  typedef struct { int code; logic [7:0] data; logic nk; string tag; } expPrim_t;
  typedef struct { int idx; logic [7:0] data; } expRd_t;
  typedef struct { int st; int rx; string tag; } expDone_t;

  expPrim_t   pq[$];
  expRd_t     rq[$];
  expDone_t   dq[$];
  logic [7:0] devQ[$];

  int nChecks = 0, nFails = 0, doneCnt = 0;
  int engNackAt = -1, engWc = 0, engCnt = 0, engCode = 0, primSeen = 0;
  int gAb = 0, gWc = 0, gSt = 0, gRx = 0, gNackAt = -1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input int i);
    return 8'hC0 ^ 8'(i * 7);
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    expPrim_t e;
    expRd_t   r;
    expDone_t d;
    if (rstN) begin
      if (priGo) begin
        if (pq.size() == 0) check(1'b0, "R1", "unexpected primitive", int'(priCmd), 0);
        else begin
          e = pq.pop_front();
          check(int'(priCmd) == e.code, e.tag, "primitive code", int'(priCmd), e.code);
          if (e.code == PR_WRITE)
            check(priData == e.data, e.tag, "written byte", int'(priData), int'(e.data));
          if (e.code == PR_READ)
            check(priNackOut == e.nk, e.tag, "read ack choice", int'(priNackOut), int'(e.nk));
        end
      end
      if (rdValid) begin
        if (rq.size() == 0) check(1'b0, "R13", "unexpected read strobe", int'(rdData), 0);
        else begin
          r = rq.pop_front();
          check(int'(rdIdx) == r.idx, "R13", "read index", int'(rdIdx), r.idx);
          check(rdData == r.data, "R13", "read byte", int'(rdData), int'(r.data));
        end
      end
      if (done) begin
        if (dq.size() == 0) check(1'b0, "R1", "unexpected done", 1, 0);
        else begin
          d = dq.pop_front();
          check(int'(status) == d.st, d.tag, "status", int'(status), d.st);
          check(int'(rxCount) == d.rx, d.tag, "received count", int'(rxCount), d.rx);
          check(busy == 1'b1, "R1", "busy during done", int'(busy), 1);
        end
        doneCnt++;
      end
    end
  end

  // Bus engine model
  always @(negedge clk) begin
    engDone = 1'b0;
    engNack = 1'b0;
    if (engCnt > 0) begin
      engCnt--;
      if (engCnt == 0) begin
        engDone = 1'b1;
        if (engCode == PR_WRITE) begin
          engNack = (engWc == engNackAt);
          engWc++;
        end
        if (engCode == PR_READ)
          engRdData = (devQ.size() > 0) ? devQ.pop_front() : 8'hEE;
      end
    end
    if (rstN && priGo) begin
      engCode = int'(priCmd);
      engCnt  = 1 + (primSeen % 3);
      primSeen++;
      if (priCmd == 3'(PR_START)) engWc = 0;
    end
  end

  task automatic pushP(input int code, input logic [7:0] data, input logic nk, input string tag);
    expPrim_t e;
    e.code = code; e.data = data; e.nk = nk; e.tag = tag;
    pq.push_back(e);
  endtask

  task automatic ew(input logic [7:0] data, input string tag);
    if (gAb != 0) return;
    pushP(PR_WRITE, data, 1'b0, tag);
    if (gWc == gNackAt) begin gAb = 1; gSt = 1; end
    gWc++;
  endtask

  task automatic rdN(input int n, input string tag);
    expRd_t r;
    for (int i = 0; i < n; i++) begin
      pushP(PR_READ, 8'h00, (i == n - 1), tag);
      r.idx = i; r.data = devByte(i);
      rq.push_back(r);
      devQ.push_back(devByte(i));
      gRx++;
    end
  endtask

  task automatic runTxn(input int t, input logic [6:0] a, input logic [7:0] c,
                        input int len, input int nackAt, input int devCnt,
                        input bit poke, input string tag);
    expDone_t d;
    int wl, lim, d0;
    bit comb;
    gAb = 0; gWc = 0; gSt = 0; gRx = 0; gNackAt = nackAt;
    devQ.delete();
    pushP(PR_START, 8'h00, 1'b0, tag);
    if (t == 0 || t > 12) begin
      ew({a, c[0]}, tag);
    end else if (t == 2) begin
      ew({a, 1'b1}, tag);
      if (gAb == 0) rdN(1, tag);
    end else begin
      ew({a, 1'b0}, tag);
      if (t != 1) ew(c, tag);
      if (t == 8 || t == 10) ew(8'(len), tag);
      wl = (t == 1 || t == 3) ? 1 : (t == 5 || t == 7) ? 2 :
           (t == 8 || t == 10 || t == 11) ? len : 0;
      for (int i = 0; i < wl; i++) ew(8'h30 + 8'(i) * 8'd3, tag);
      comb = (t == 4 || t == 6 || t == 7 || t == 9 || t == 10 || t == 12);
      if (comb && gAb == 0) begin
        pushP(PR_RSTART, 8'h00, 1'b0, tag);
        ew({a, 1'b1}, tag);
        if (gAb == 0) begin
          if (t == 9 || t == 10) begin
            pushP(PR_READ, 8'h00, 1'b0, tag);
            devQ.push_back(8'(devCnt));
            lim = (t == 10) ? MAXB - 1 : MAXB;
            if (devCnt == 0 || devCnt > lim) gSt = 2;
            else rdN(devCnt, tag);
          end else begin
            rdN((t == 4) ? 1 : (t == 12) ? len : 2, tag);
          end
        end
      end
    end
    pushP(PR_STOP, 8'h00, 1'b0, tag);
    d.st = gSt; d.rx = gRx; d.tag = tag;
    dq.push_back(d);
    engNackAt = nackAt;

    d0 = doneCnt;
    @(negedge clk);
    reqValid = 1'b1; reqType = 4'(t); reqAddr = a; reqCmd = c; reqLen = IW'(len);
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R1: request while busy must be ignored
      reqValid = 1'b1; reqType = 4'(T_RECV); reqAddr = 7'h7F;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (doneCnt == d0) @(negedge clk);
    check(pq.size() == 0, tag, "primitives left over", pq.size(), 0);
    check(rq.size() == 0, "R13", "reads left over", rq.size(), 0);
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after done", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && priGo == 1'b0 && done == 1'b0 && rdValid == 1'b0,
          "R1", "reset outputs", int'({busy, priGo, done, rdValid}), 0);
    rstN = 1'b1;
    @(negedge clk);

    runTxn(0,  7'h2A, 8'h00, 0, -1, 0, 0, "R2");   // quick, write direction
    runTxn(0,  7'h15, 8'h01, 0, -1, 0, 0, "R2");   // quick, read direction
    runTxn(14, 7'h33, 8'h01, 0, -1, 0, 0, "R1");   // reserved code acts as quick
    runTxn(1,  7'h40, 8'h00, 0, -1, 0, 0, "R3");   // send byte
    runTxn(3,  7'h41, 8'h9C, 0, -1, 0, 0, "R3");   // write byte
    runTxn(5,  7'h42, 8'h11, 0, -1, 0, 0, "R3");   // write word
    runTxn(2,  7'h50, 8'h00, 0, -1, 0, 0, "R4");   // receive byte
    runTxn(4,  7'h51, 8'h22, 0, -1, 0, 0, "R5");   // read byte
    runTxn(6,  7'h52, 8'h23, 0, -1, 0, 1, "R5");   // read word with a poke while busy
    runTxn(7,  7'h53, 8'h24, 0, -1, 0, 0, "R6");   // process call
    runTxn(8,  7'h60, 8'h31, 3, -1, 0, 0, "R7");   // block write short
    runTxn(8,  7'h60, 8'h32, MAXB, -1, 0, 0, "R7");// block write full
    runTxn(9,  7'h61, 8'h41, 0, -1, 4, 0, "R8");   // block read four
    runTxn(9,  7'h61, 8'h42, 0, -1, MAXB, 0, "R8");// block read full
    runTxn(9,  7'h62, 8'h43, 0, -1, 0, 0, "R9");   // zero count
    runTxn(9,  7'h62, 8'h44, 0, -1, MAXB + 1, 0, "R9"); // count over limit
    runTxn(10, 7'h63, 8'h45, 2, -1, MAXB, 0, "R9");     // process-call limit is one lower
    runTxn(10, 7'h64, 8'h51, 2, -1, 3, 0, "R10");
    runTxn(10, 7'h64, 8'h52, MAXB - 1, -1, MAXB - 1, 0, "R10");
    runTxn(11, 7'h70, 8'h61, 5, -1, 0, 0, "R11");  // I2C block write
    runTxn(12, 7'h71, 8'h62, 7, -1, 0, 0, "R11");  // I2C block read
    runTxn(12, 7'h71, 8'h63, 1, -1, 0, 0, "R11");  // single byte I2C read
    runTxn(3,  7'h05, 8'h10, 0, 0, 0, 0, "R12");   // address refused
    runTxn(8,  7'h06, 8'h11, 4, 4, 0, 0, "R12");   // second data byte refused
    runTxn(6,  7'h07, 8'h12, 0, 2, 0, 0, "R12");   // read address refused
    runTxn(4,  7'h08, 8'h13, 0, -1, 0, 0, "R5");   // clean run after errors

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule